// File: doc/BRIEF.md
# TPM Command-Buffer Control Registers

This block is the register front end of a TPM that exchanges commands and responses through a shared memory buffer. Host software reaches it over a simple byte-addressed register bus. The block lets software claim and release a locality, and move the TPM between its idle and ready power states. It also lets software launch a command or ask for one to be cancelled. It shows the progress and error state of the command in the status registers. The buffer memory and the command engine are outside the block. Towards the engine it drives a one-cycle launch pulse and a one-cycle cancel pulse. It receives a completion strobe with an error flag, and a level input that reports whether the platform trust state has been established.

Every control register decodes the whole written value and compares it for equality with one defined code. Any other value, including a value with several code bits set, does nothing.

Three small state machines hold the state:

- **Locality machine.** States `LOC_FREE` and `LOC_HELD`. The `GRANT` transition is taken on a request-access code. The `RELEASE` transition is taken on a relinquish code.
- **Power machine.** States `PWR_IDLE` and `PWR_READY`. The `WAKE` transition is taken on a command-ready code. The `SLEEP` transition is taken on a go-idle code.
- **Command machine.** States `CMD_CLEAR` and `CMD_PENDING`. The `LAUNCH` transition is taken on an accepted start write. The `FINISH` transition is taken on the completion strobe.

A sticky fatal flag records any completion that reports an error.

Top module: `tpm_cmdbuf_regs`

## Requirements
- R1: After reset, the registers read as follows: offset 0x000 (locality state) reads 0x80 while `est_flag` is 1; offset 0x044 (control status) reads 0x2, which is idle set and fatal clear; offsets 0x00C (locality status) and 0x04C (start) read 0.
- R2: The following registers are constants:
  - Offset 0x030 (interface identity) reads 0x00025811. Its fields are: type=1 in [3:0], version=1 in [7:4], transfer-size capability 0b11 in [12:11], buffer-interface capability in bit 14, and selector=1 in [18:17].
  - Offsets 0x058 (command size) and 0x064 (response size) read WIN_SIZE−DATA_OFS, which is 0xF80 by default.
  - Offsets 0x05C (command address) and 0x068 (response address) read BASE_ADDR+DATA_OFS, which is 0xFED40080 by default.
- R3: A write to offset 0x008 (locality control) works as follows:
  - Value 0x1 takes a locality. Locality status bit 0 (granted) becomes 1, locality status bit 1 (seized) becomes 0, and locality state bit 1 (assigned) becomes 1.
  - Value 0x2 clears both the granted bit and the assigned bit.
  - Value 0x8, and every other value, has no effect.
- R4: A write to offset 0x040 (control request) works as follows:
  - Value 0x1 clears the idle bit, which is control status bit 1.
  - Value 0x2 sets the idle bit.
  - Any other value is ignored.
- R5: A write of 0x1 to the start register (offset 0x04C) is accepted only when all of the following hold:
  - No command is pending.
  - A locality is held.
  - Address bits [15:12] equal the active locality. The active locality is 0 while a locality is held and reads as 0xFF when none is held.

  An accepted write sets start bit 0 and raises `eng_start` for exactly one cycle. A refused write changes nothing.
- R6: A write of 0x1 to offset 0x048 (cancel) raises `eng_cancel` for one cycle only while a command is pending. Any other value, or the same write while no command is pending, produces no pulse.
- R7: On `eng_done`, the start bit clears. If `eng_err` is 1 at that time, control status bit 0 (fatal) sets and stays set until reset.
- R8: A read returns the addressed 32-bit word shifted right by 8×`bus_addr[1:0]`, so that narrow accesses see little-endian byte lanes.
- R9: Bit 0 of the locality-state word reads as the inverse of `est_flag`, combinationally.
- R10: Reads of undecoded or write-only offsets return 0. Writes to read-only or undecoded offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Byte address; [15:12] locality page, [11:0] register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| eng_start | output | 1 | One-cycle command launch pulse |
| eng_cancel | output | 1 | One-cycle cancel pulse |
| eng_done | input | 1 | Command completion strobe |
| eng_err | input | 1 | Error flag qualifying `eng_done` |
| est_flag | input | 1 | Trust-establishment status level |

## Verification
Read data depends only on the address and the current state, so it is checked within the same cycle that the address is applied. The effect of a write on register state appears after the clock edge that samples `bus_wr`. Likewise, a launch or cancel pulse is high for exactly the cycle that follows that edge. The completion strobe clears the start bit, and sets the fatal flag when `eng_err` is 1, at the edge on which `eng_done` is sampled. The bench drives every stimulus for one full cycle starting at a falling edge. It samples at the next falling edge, which is half a cycle after the edge that registered the stimulus, and it samples again one cycle later to confirm that each pulse has dropped.

// File: rtl/tpm_cmdbuf_pkg.sv
package tpm_cmdbuf_pkg;

    // Register offsets within a locality page
    localparam logic [11:0] OFS_LOC_STATE   = 12'h000;
    localparam logic [11:0] OFS_LOC_CTRL    = 12'h008;
    localparam logic [11:0] OFS_LOC_STS     = 12'h00C;
    localparam logic [11:0] OFS_INTF_ID     = 12'h030;
    localparam logic [11:0] OFS_CTRL_REQ    = 12'h040;
    localparam logic [11:0] OFS_CTRL_STS    = 12'h044;
    localparam logic [11:0] OFS_CTRL_CANCEL = 12'h048;
    localparam logic [11:0] OFS_CTRL_START  = 12'h04C;
    localparam logic [11:0] OFS_CMD_SIZE    = 12'h058;
    localparam logic [11:0] OFS_CMD_ADDR    = 12'h05C;
    localparam logic [11:0] OFS_RSP_SIZE    = 12'h064;
    localparam logic [11:0] OFS_RSP_ADDR    = 12'h068;

    // Exact-match command codes
    localparam logic [31:0] CODE_TAKE_LOC   = 32'h1;
    localparam logic [31:0] CODE_DROP_LOC   = 32'h2;
    localparam logic [31:0] CODE_WAKE       = 32'h1;
    localparam logic [31:0] CODE_SLEEP      = 32'h2;
    localparam logic [31:0] CODE_INVOKE     = 32'h1;

    localparam logic [7:0]  NO_LOCALITY     = 8'hFF;
    localparam logic [7:0]  HOME_LOCALITY   = 8'h00;

    typedef enum logic { LOC_FREE,  LOC_HELD    } loc_state_e;
    typedef enum logic { PWR_IDLE,  PWR_READY   } pwr_state_e;
    typedef enum logic { CMD_CLEAR, CMD_PENDING } cmd_state_e;

    // Interface identity word, built from its fields
    function automatic logic [31:0] intf_id_word();
        logic [31:0] w;
        w        = '0;
        w[3:0]   = 4'd1;   // interface type: buffer active
        w[7:4]   = 4'd1;   // interface version
        w[8]     = 1'b0;   // locality 0 only
        w[9]     = 1'b0;   // no idle bypass
        w[12:11] = 2'b11;  // 64-byte transfers
        w[13]    = 1'b0;   // no FIFO interface
        w[14]    = 1'b1;   // buffer interface present
        w[18:17] = 2'd1;   // selector
        w[31:24] = 8'd0;   // revision
        return w;
    endfunction

endpackage

// File: rtl/tpm_cmdbuf_loc.sv
module tpm_cmdbuf_loc
    import tpm_cmdbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] wdata,
    output logic        held,
    output logic [7:0]  active_loc
);

    loc_state_e loc_q, loc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) loc_q <= LOC_FREE;
        else        loc_q <= loc_d;
    end

    // GRANT / RELEASE transitions
    always_comb begin
        loc_d = loc_q;
        if (ctrl_wr) begin
            unique case (loc_q)
                LOC_FREE: if (wdata == CODE_TAKE_LOC) loc_d = LOC_HELD;
                LOC_HELD: if (wdata == CODE_DROP_LOC) loc_d = LOC_FREE;
            endcase
        end
    end

    always_comb begin
        held       = (loc_q == LOC_HELD);
        active_loc = held ? HOME_LOCALITY : NO_LOCALITY;
    end

endmodule

// File: rtl/tpm_cmdbuf_seq.sv
module tpm_cmdbuf_seq
    import tpm_cmdbuf_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              start_wr,
    input  logic              cancel_wr,
    input  logic [31:0]       wdata,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [7:0]        active_loc,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic              eng_start,
    output logic              eng_cancel,
    output logic              pending,
    output logic              idle,
    output logic              fatal
);

    cmd_state_e cmd_q, cmd_d;
    pwr_state_e pwr_q, pwr_d;
    logic       start_q, cancel_q, fatal_q;
    logic       start_ok, cancel_ok;

    assign start_ok  = start_wr && (wdata == CODE_INVOKE) && (cmd_q == CMD_CLEAR)
                    && (active_loc != NO_LOCALITY)
                    && (active_loc == 8'(wr_page));
    assign cancel_ok = cancel_wr && (wdata == CODE_INVOKE) && (cmd_q == CMD_PENDING);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_CLEAR;
            pwr_q    <= PWR_IDLE;
            start_q  <= 1'b0;
            cancel_q <= 1'b0;
            fatal_q  <= 1'b0;
        end else begin
            cmd_q    <= cmd_d;
            pwr_q    <= pwr_d;
            start_q  <= start_ok;
            cancel_q <= cancel_ok;
            fatal_q  <= fatal_q | (eng_done & eng_err);
        end
    end

    // LAUNCH / FINISH and WAKE / SLEEP transitions
    always_comb begin
        cmd_d = cmd_q;
        unique case (cmd_q)
            CMD_CLEAR:   if (start_ok) cmd_d = CMD_PENDING;
            CMD_PENDING: if (eng_done) cmd_d = CMD_CLEAR;
        endcase
        pwr_d = pwr_q;
        if (req_wr) begin
            unique case (pwr_q)
                PWR_IDLE:  if (wdata == CODE_WAKE)  pwr_d = PWR_READY;
                PWR_READY: if (wdata == CODE_SLEEP) pwr_d = PWR_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_start  = start_q;
        eng_cancel = cancel_q;
        pending    = (cmd_q == CMD_PENDING);
        idle       = (pwr_q == PWR_IDLE);
        fatal      = fatal_q;
    end

endmodule

// File: rtl/tpm_cmdbuf_rdmux.sv
module tpm_cmdbuf_rdmux
    import tpm_cmdbuf_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_1000,
    parameter logic [31:0] DATA_OFS  = 32'h0000_0080
) (
    input  logic [11:0] ofs,
    input  logic        held,
    input  logic [2:0]  loc_field,
    input  logic        est_flag,
    input  logic        idle,
    input  logic        fatal,
    input  logic        pending,
    output logic [31:0] rdata
);

    localparam logic [31:0] BUF_SIZE = WIN_SIZE - DATA_OFS;
    localparam logic [31:0] BUF_ADDR = BASE_ADDR + DATA_OFS;

    logic [31:0] word;

    always_comb begin
        unique case ({ofs[11:2], 2'b00})
            OFS_LOC_STATE:  word = {24'h0, 1'b1, 2'b00, loc_field, held, ~est_flag};
            OFS_LOC_STS:    word = {30'h0, 1'b0, held};
            OFS_INTF_ID:    word = intf_id_word();
            OFS_CTRL_STS:   word = {30'h0, idle, fatal};
            OFS_CTRL_START: word = {31'h0, pending};
            OFS_CMD_SIZE:   word = BUF_SIZE;
            OFS_CMD_ADDR:   word = BUF_ADDR;
            OFS_RSP_SIZE:   word = BUF_SIZE;
            OFS_RSP_ADDR:   word = BUF_ADDR;
            default:        word = 32'h0;
        endcase
        rdata = word >> {ofs[1:0], 3'b000};
    end

endmodule

// File: rtl/tpm_cmdbuf_regs.sv
module tpm_cmdbuf_regs
    import tpm_cmdbuf_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_1000,
    parameter logic [31:0] DATA_OFS  = 32'h0000_0080
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [15:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        eng_start,
    output logic        eng_cancel,
    input  logic        eng_done,
    input  logic        eng_err,
    input  logic        est_flag
);

    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = 16 - PAGE_LSB;

    logic [11:0]       ofs;
    logic [PAGE_W-1:0] page;
    logic              loc_wr, req_wr, start_wr, cancel_wr;
    logic              loc_held, cmd_pending, pwr_idle, sts_fatal;
    logic [7:0]        active_loc;

    assign ofs       = bus_addr[PAGE_LSB-1:0];
    assign page      = bus_addr[15:PAGE_LSB];
    assign loc_wr    = bus_wr && (ofs == OFS_LOC_CTRL);
    assign req_wr    = bus_wr && (ofs == OFS_CTRL_REQ);
    assign start_wr  = bus_wr && (ofs == OFS_CTRL_START);
    assign cancel_wr = bus_wr && (ofs == OFS_CTRL_CANCEL);

    tpm_cmdbuf_loc u_loc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (loc_wr),
        .wdata      (bus_wdata),
        .held       (loc_held),
        .active_loc (active_loc)
    );

    tpm_cmdbuf_seq #(.PAGE_W(PAGE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr     (req_wr),
        .start_wr   (start_wr),
        .cancel_wr  (cancel_wr),
        .wdata      (bus_wdata),
        .wr_page    (page),
        .active_loc (active_loc),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .eng_start  (eng_start),
        .eng_cancel (eng_cancel),
        .pending    (cmd_pending),
        .idle       (pwr_idle),
        .fatal      (sts_fatal)
    );

    tpm_cmdbuf_rdmux #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_SIZE  (WIN_SIZE),
        .DATA_OFS  (DATA_OFS)
    ) u_rdmux (
        .ofs       (ofs),
        .held      (loc_held),
        .loc_field (loc_held ? active_loc[2:0] : 3'b000),
        .est_flag  (est_flag),
        .idle      (pwr_idle),
        .fatal     (sts_fatal),
        .pending   (cmd_pending),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/tpm_cmdbuf_regs_chk.sv
module tpm_cmdbuf_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        eng_start,
    input logic        eng_cancel,
    input logic        eng_done,
    input logic        eng_err,
    input logic        pending,
    input logic        fatal,
    input logic        held
);

    // R5: launch pulse lasts one cycle
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5: launch only after an accepted start write from page 0 with a held locality
    a_r5_start_source: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(bus_wr && bus_addr == 16'h004C && bus_wdata == 32'h1
                            && held && !pending));

    // R5: launch leaves a command pending
    a_r5_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> pending);

    // R6: cancel pulse only while pending
    a_r6_cancel_gated: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cancel |-> $past(pending));

    // R7: completion clears pending
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && pending) |=> !pending);

    // R7: errored completion sets fatal
    a_r7_err_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_err) |=> fatal);

    // R7: fatal is sticky
    a_r7_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

    // R3: relinquish releases the locality
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[11:0] == 12'h008 && bus_wdata == 32'h2) |=> !held);

endmodule

bind tpm_cmdbuf_regs tpm_cmdbuf_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .eng_start  (eng_start),
    .eng_cancel (eng_cancel),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .pending    (cmd_pending),
    .fatal      (sts_fatal),
    .held       (loc_held)
);

// File: tb/tpm_cmdbuf_regs_tb.sv
`timescale 1ns/1ps
module tpm_cmdbuf_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start, eng_cancel;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic        est_flag = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tpm_cmdbuf_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_cancel(eng_cancel), .eng_done(eng_done), .eng_err(eng_err),
        .est_flag(est_flag)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] waddr;
        logic [31:0] wdata;
        logic [15:0] raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'h0000, 32'h0,        16'h0000, 32'h80,        8'd1},  // R1
        '{1'b0, 16'h0000, 32'h0,        16'h0044, 32'h2,         8'd1},  // R1
        '{1'b0, 16'h0000, 32'h0,        16'h000C, 32'h0,         8'd1},  // R1
        '{1'b0, 16'h0000, 32'h0,        16'h004C, 32'h0,         8'd1},  // R1
        '{1'b0, 16'h0000, 32'h0,        16'h0030, 32'h25811,     8'd2},  // R2
        '{1'b0, 16'h0000, 32'h0,        16'h0058, 32'hF80,       8'd2},  // R2
        '{1'b0, 16'h0000, 32'h0,        16'h005C, 32'hFED40080,  8'd2},  // R2
        '{1'b0, 16'h0000, 32'h0,        16'h0064, 32'hF80,       8'd2},  // R2
        '{1'b0, 16'h0000, 32'h0,        16'h0068, 32'hFED40080,  8'd2},  // R2
        '{1'b1, 16'h0008, 32'h8,        16'h000C, 32'h0,         8'd3},  // R3
        '{1'b1, 16'h0008, 32'h3,        16'h0000, 32'h80,        8'd3},  // R3
        '{1'b1, 16'h0008, 32'h1,        16'h000C, 32'h1,         8'd3},  // R3
        '{1'b0, 16'h0000, 32'h0,        16'h0000, 32'h82,        8'd3},  // R3
        '{1'b1, 16'h0040, 32'h3,        16'h0044, 32'h2,         8'd4},  // R4
        '{1'b1, 16'h0040, 32'h1,        16'h0044, 32'h0,         8'd4},  // R4
        '{1'b1, 16'h0040, 32'h2,        16'h0044, 32'h2,         8'd4},  // R4
        '{1'b1, 16'h0040, 32'h1,        16'h0044, 32'h0,         8'd4},  // R4
        '{1'b1, 16'h0030, 32'h0,        16'h0030, 32'h25811,     8'd10}, // R10
        '{1'b1, 16'h0100, 32'hFFFFFFFF, 16'h0100, 32'h0,         8'd10}, // R10
        '{1'b0, 16'h0000, 32'h0,        16'h0008, 32'h0,         8'd10}, // R10
        '{1'b0, 16'h0000, 32'h0,        16'h0048, 32'h0,         8'd10}, // R10
        '{1'b0, 16'h0000, 32'h0,        16'h0031, 32'h258,       8'd8},  // R8
        '{1'b0, 16'h0000, 32'h0,        16'h0032, 32'h2,         8'd8},  // R8
        '{1'b0, 16'h0000, 32'h0,        16'h0033, 32'h0,         8'd8},  // R8
        '{1'b1, 16'h104C, 32'h1,        16'h004C, 32'h0,         8'd5},  // R5
        '{1'b1, 16'h004C, 32'h3,        16'h004C, 32'h0,         8'd5}   // R5
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic done_pulse(logic err);
        @(negedge clk);
        eng_done = 1'b1; eng_err = err;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table: optional write, then a read check
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) begin
                wr_reg(TBL[i].waddr, TBL[i].wdata);
                check("R5 no launch from table", {31'h0, eng_start}, 32'h0);
            end
            rd_chk($sformatf("R%0d vec %0d", TBL[i].req, i), TBL[i].raddr, TBL[i].exp);
        end

        // R6: cancel with nothing pending
        wr_reg(16'h0048, 32'h1);
        check("R6 cancel idle", {31'h0, eng_cancel}, 32'h0);

        // R5: accepted launch
        wr_reg(16'h004C, 32'h1);
        check("R5 launch pulse", {31'h0, eng_start}, 32'h1);
        rd_chk("R5 start bit", 16'h004C, 32'h1);
        @(negedge clk);
        check("R5 pulse width", {31'h0, eng_start}, 32'h0);
        wr_reg(16'h004C, 32'h1);
        check("R5 relaunch refused", {31'h0, eng_start}, 32'h0);

        // R6: cancel codes while pending
        wr_reg(16'h0048, 32'h3);
        check("R6 bad cancel code", {31'h0, eng_cancel}, 32'h0);
        wr_reg(16'h0048, 32'h1);
        check("R6 cancel pulse", {31'h0, eng_cancel}, 32'h1);
        @(negedge clk);
        check("R6 cancel width", {31'h0, eng_cancel}, 32'h0);

        // R7: clean completion
        done_pulse(1'b0);
        rd_chk("R7 start cleared", 16'h004C, 32'h0);
        rd_chk("R7 no fatal", 16'h0044, 32'h0);

        // R3 / R5: release then launch refused
        wr_reg(16'h0008, 32'h2);
        rd_chk("R3 released sts", 16'h000C, 32'h0);
        rd_chk("R3 released state", 16'h0000, 32'h80);
        wr_reg(16'h004C, 32'h1);
        check("R5 no locality", {31'h0, eng_start}, 32'h0);
        rd_chk("R5 no locality bit", 16'h004C, 32'h0);

        // R7: errored completion, sticky
        wr_reg(16'h0008, 32'h1);
        wr_reg(16'h004C, 32'h1);
        check("R5 launch again", {31'h0, eng_start}, 32'h1);
        done_pulse(1'b1);
        rd_chk("R7 fatal set", 16'h0044, 32'h1);
        done_pulse(1'b0);
        rd_chk("R7 fatal sticky", 16'h0044, 32'h1);
        rd_chk("R7 start clear", 16'h004C, 32'h0);

        // R9: establishment input
        est_flag = 1'b0;
        rd_chk("R9 est low", 16'h0000, 32'h83);
        est_flag = 1'b1;
        rd_chk("R9 est high", 16'h0000, 32'h82);

        // R1: reset from busy state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1 sts after reset", 16'h0044, 32'h2);
        rd_chk("R1 loc sts after reset", 16'h000C, 32'h0);
        rd_chk("R1 start after reset", 16'h004C, 32'h0);
        rd_chk("R1 loc state after reset", 16'h0000, 32'h80);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule